// File: doc/BRIEF.md
# Random Bus Traffic Generator

This block is a synthesizable master for a simple synchronous command bus. Each rising clock edge it registers a new 2-bit command, a 16-bit address, a 32-bit write data word and an enable that says whether the data word is being driven. The command, address and data values all come from one internal linear-feedback shift register. The block is used as a traffic source in front of a memory-like target so that the target can be exercised without a hand-written stimulus list.

After a read the bus protocol reserves the next cycle for the returned data. The generator honours this by issuing a DATA command after every READ and only then choosing freely again. After a synchronous reset it stays quiet for a parameterised number of cycles before any traffic starts.

The bus has no back-pressure: there is no ready signal and the target must accept one command every cycle. For the same reason there is no valid signal. IDLE is the "nothing to do" command.

Top module: `rbus_traffic_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `bus_cmd`=0 (IDLE), `bus_addr`=0, `bus_wdata_en`=0 and `bus_wdata`=0.
- R2: For the first START_DELAY clock edges after `rst` goes low, the outputs stay at IDLE, with address 0 and the data released (enable 0, data 0).
- R3: After the start-up delay, unless R4 applies, the command is chosen from bits [1:0] of the current random state. The mapping is 0 to IDLE(0), 1 to WRITE(1), 2 to READ(2) and 3 to IDLE(0). The command encoding is IDLE=0, WRITE=1, READ=2, DATA=3.
- R4: When the command currently on the bus is READ, the next command is DATA(3), whatever the random state holds.
- R5: On WRITE, `bus_wdata_en` is 1 and `bus_wdata` is bits [31:16] of the current random state, zero-extended to 32 bits.
- R6: On IDLE, READ and DATA, `bus_wdata_en` is 0 and `bus_wdata` is 0.
- R7: On WRITE and READ, `bus_addr` is bits [5:2] of the current random state, zero-extended, so it lies in 0..15.
- R8: On IDLE and DATA, `bus_addr` keeps its previous value.
- R9: The random state is 32 bits. It is loaded with SEED while `rst` is high. At every other edge it moves to {s[30:0], s[31]^s[21]^s[1]^s[0]}. The "current" state is its value just before the edge that registers the outputs. The state is never zero.
- R10: Two READ commands never appear in consecutive cycles, and DATA only ever follows READ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every output changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_cmd | output | 2 | Command: IDLE=0, WRITE=1, READ=2, DATA=3 |
| bus_addr | output | 16 | Target address, 0..15 when newly chosen |
| bus_wdata | output | 32 | Write data, zero when released |
| bus_wdata_en | output | 1 | High only while a WRITE drives the data word |

## Verification
The bench carries its own model of the shift register and the command rules. It compares every output field on every cycle, so random commands, addresses and data are all checked against values the bench predicts. The same long run covers two patterns. One is runs of non-read commands, which show address holding and data release on IDLE. The other is READ cycles, whose random low bits would often have picked something other than DATA next, so they separate the forced data phase from the random choice. A mid-run reset repeats the quiet start-up window. This tells the delay counting apart from an LFSR-only reset, and it confirms that traffic resumes from the seed.

// File: rtl/rbg_pkg.sv
package rbg_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_READ  = 2'd2,
    CMD_DATA  = 2'd3
  } bus_cmd_e;
endpackage

// File: rtl/rbg_lfsr.sv
module rbg_lfsr #(
  parameter int          W    = 32,
  parameter logic [31:0] SEED = 32'hACE1_2B47
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] state
);
  logic         fb;
  logic [W-1:0] state_q;

  // taps 32,22,2,1: maximal length
  assign fb = state_q[31] ^ state_q[21] ^ state_q[1] ^ state_q[0];

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED[W-1:0];
    else     state_q <= {state_q[W-2:0], fb};
  end

  assign state = state_q;

  // R9
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    state_q != '0);
endmodule

// File: rtl/rbg_start_delay.sv
module rbg_start_delay #(
  parameter int START_DELAY = 8
) (
  input  logic clk,
  input  logic rst,
  output logic go
);
  localparam int CW = (START_DELAY < 1) ? 1 : $clog2(START_DELAY + 1);
  localparam logic [CW-1:0] LIMIT = CW'(START_DELAY);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign go = (cnt_q == LIMIT);

  // R2
  delay_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    go |=> go);
endmodule

// File: rtl/rbg_sequencer.sv
module rbg_sequencer
  import rbg_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int RND_W     = 32,
  parameter int ADDR_BITS = 4,
  parameter int WD_BITS   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [RND_W-1:0]  rnd,
  output bus_cmd_e          cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              wdata_en
);
  localparam int ADDR_LSB = 2;
  localparam int WD_LSB   = RND_W - WD_BITS;

  bus_cmd_e          cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wd_q, wd_d;
  logic              en_q, en_d;

  always_comb begin
    cmd_d  = CMD_IDLE;
    addr_d = addr_q;
    wd_d   = '0;
    en_d   = 1'b0;
    if (go) begin
      if (cmd_q == CMD_READ) begin
        cmd_d = CMD_DATA;
      end else begin
        unique case (rnd[1:0])
          2'd1: begin
            cmd_d  = CMD_WRITE;
            addr_d = ADDR_W'(rnd[ADDR_LSB +: ADDR_BITS]);
            wd_d   = DATA_W'(rnd[WD_LSB +: WD_BITS]);
            en_d   = 1'b1;
          end
          2'd2: begin
            cmd_d  = CMD_READ;
            addr_d = ADDR_W'(rnd[ADDR_LSB +: ADDR_BITS]);
          end
          default: cmd_d = CMD_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= CMD_IDLE;
      addr_q <= '0;
      wd_q   <= '0;
      en_q   <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
      en_q   <= en_d;
    end
  end

  assign cmd      = cmd_q;
  assign addr     = addr_q;
  assign wdata    = wd_q;
  assign wdata_en = en_q;

  // R4
  read_then_data_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_READ) |=> (cmd_q == CMD_DATA));
  // R10
  data_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_DATA) |-> ($past(cmd_q) == CMD_READ));
  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_IDLE || cmd_q == CMD_DATA) |-> $stable(addr_q));
  // R5
  wdata_width_chk: assert property (@(posedge clk) disable iff (rst)
    en_q |-> (wd_q >> WD_BITS) == '0);
  // R7
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_q >> ADDR_BITS) == '0);
endmodule

// File: rtl/rbus_traffic_gen.sv
module rbus_traffic_gen
  import rbg_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 32,
  parameter int          ADDR_BITS   = 4,
  parameter int          WD_BITS     = 16,
  parameter int          START_DELAY = 8,
  parameter logic [31:0] SEED        = 32'hACE1_2B47
) (
  input  logic              clk,
  input  logic              rst,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wdata_en
);
  localparam int RND_W = 32;

  logic [RND_W-1:0] rnd;
  logic             go;
  bus_cmd_e         cmd;

  rbg_lfsr #(.W(RND_W), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst(rst), .state(rnd)
  );

  rbg_start_delay #(.START_DELAY(START_DELAY)) u_delay (
    .clk(clk), .rst(rst), .go(go)
  );

  rbg_sequencer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RND_W(RND_W),
    .ADDR_BITS(ADDR_BITS), .WD_BITS(WD_BITS)
  ) u_seq (
    .clk(clk), .rst(rst), .go(go), .rnd(rnd),
    .cmd(cmd), .addr(bus_addr), .wdata(bus_wdata), .wdata_en(bus_wdata_en)
  );

  assign bus_cmd = cmd;

  // R2
  quiet_start_chk: assert property (@(posedge clk) disable iff (rst)
    !go |=> (bus_cmd == CMD_IDLE && !bus_wdata_en));
  // R6
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd != CMD_WRITE) |-> (!bus_wdata_en && bus_wdata == '0));
endmodule

// File: tb/sim_rbus_traffic_gen.sv
module sim_rbus_traffic_gen;
  localparam int D = 8;
  localparam logic [31:0] SEED = 32'hACE1_2B47;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_cmd;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_wdata_en;

  int compared = 0, mismatched = 0, writes = 0, reads = 0;
  bit done = 0;

  typedef struct {
    logic [1:0] c; logic [15:0] a; logic [31:0] d; logic e;
    string tc; string ta; string td;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  rbus_traffic_gen #(.START_DELAY(D), .SEED(SEED)) u0 (
    .clk(clk), .rst(rst), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wdata_en(bus_wdata_en)
  );

  // predictor: model from R1..R9, pushes one expected item per edge
  logic [31:0] s;
  logic [1:0]  pc;
  logic [15:0] pa;
  int          cnt;
  always @(posedge clk) begin
    exp_t x;
    if (rst) begin
      s = SEED; pc = 0; pa = 0; cnt = 0;
      x = '{2'd0, 16'd0, 32'd0, 1'b0, "R1", "R1", "R1"};
    end else begin
      if (cnt < D) begin
        cnt++;
        x = '{2'd0, pa, 32'd0, 1'b0, "R2", "R2", "R2"};
      end else if (pc == 2'd2) begin
        x = '{2'd3, pa, 32'd0, 1'b0, "R4", "R8", "R6"};
      end else if (s[1:0] == 2'd1) begin
        pa = {12'd0, s[5:2]};
        x = '{2'd1, pa, {16'd0, s[31:16]}, 1'b1, "R3", "R7", "R5"};
      end else if (s[1:0] == 2'd2) begin
        pa = {12'd0, s[5:2]};
        x = '{2'd2, pa, 32'd0, 1'b0, "R3", "R7", "R6"};
      end else begin
        x = '{2'd0, pa, 32'd0, 1'b0, "R3", "R8", "R6"};
      end
      pc = x.c;
      s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]}; // R9
    end
    q.push_back(x);
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // monitor: pops and compares away from the active edge
  logic [1:0] last_cmd = 2'd0;
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      chk(x.tc, {30'd0, bus_cmd}, {30'd0, x.c});
      chk(x.ta, {16'd0, bus_addr}, {16'd0, x.a});
      chk(x.td, bus_wdata, x.d);
      chk(x.td, {31'd0, bus_wdata_en}, {31'd0, x.e});
      // R10: no back-to-back reads
      chk("R10", {31'd0, (last_cmd == 2'd2 && bus_cmd == 2'd2)}, 32'd0);
      if (bus_cmd == 2'd1) writes++;
      if (bus_cmd == 2'd2) reads++;
      last_cmd = rst ? 2'd0 : bus_cmd;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (400) @(negedge clk);
    rst = 1'b1;                       // second pattern: mid-run reset
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (200) @(negedge clk);
    compared++;
    if (writes == 0 || reads == 0) begin
      mismatched++;
      $display("FAIL R3 coverage: actual writes=%0d reads=%0d expected both > 0",
               writes, reads);
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule